// File: doc/BRIEF.md
# CHS to LBA Address Translator

This block turns the address fields of an ATA-style task file into a linear sector index. The caller presents the register values and a one-cycle operation strobe with an operation code. A translate operation reads the device/head register to pick the mode. In linear mode the fields are packed directly into a 28-bit index. In cylinder/head/sector mode the fields are checked against the current logical geometry. If they fit, the index is computed as (cylinder × heads + head) × sectors + sector − 1.

The block also keeps the logical geometry. A load operation takes the drive's native parameters. When the native head count is above 16, it substitutes a 16-head, 63-sector layout and derives the cylinder count by dividing the total block count. A set-geometry operation takes the sectors per track and the head count from the task file and divides the total block count by their product. A recalibrate operation returns the register values that the task file should hold after a seek to the first sector.

Multiplication is done by a sequential shift-add unit and division by a restoring shift-subtract unit. Every operation therefore takes a variable number of cycles and ends with a single-cycle `done`.

Top module: `chs_lba_xlat`

## Requirements
- R1: In a translate operation (op code 0) with device/head bit 6 set, `lba` = {device/head[3:0], cylinder high byte, cylinder low byte, sector}. `addr_err` = 0 whatever the stored geometry is.
- R2: In a translate operation with bit 6 clear, cylinder = {high byte, low byte} and head = device/head[3:0]. `lba` = (cylinder × H + head) × S + sector − 1, computed with the stored heads H and sectors per track S.
- R3: A translate operation with bit 6 clear sets `addr_err` when cylinder ≥ C, head ≥ H, sector = 0 or sector > S. `addr_err` is 0 for every other operation code.
- R4: Set geometry (op code 1) sets S to the sector-count input (0 means 256) and H to device/head[3:0] + 1. It sets C to the total block count divided by S × H, rounded down.
- R5: Load defaults (op code 2) copies the native cylinders, heads and sectors when native heads ≤ 16. Otherwise it sets H = 16, S = 63 and C = total blocks / 1008, rounded down.
- R6: Recalibrate (op code 3) returns cylinder 0 and device/head with bits 3:0 cleared and the upper bits kept. It returns sector 0 when bit 6 is set and sector 1 when bit 6 is clear.
- R7: Each accepted operation produces exactly one `done` pulse one cycle wide. `busy` is high from the cycle after acceptance until `done`. Results are valid in the `done` cycle and hold until the next `done`.
- R8: After reset, `busy` and `done` are low and the geometry is C = H = S = 0, so every cylinder/head/sector translation is rejected. A zero divisor yields C = 0.
- R9: An operation strobe while `busy` is high is ignored. It causes no `done` and no change to the geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 2 | 0 translate, 1 set geometry, 2 load defaults, 3 recalibrate |
| tf_devhd | input | 8 | Device/head register (bit 6 linear mode, bits 3:0 head) |
| tf_scnt | input | 8 | Sector count register |
| tf_sect | input | 8 | Sector number register |
| tf_cyl | input | 16 | Cylinder {high, low} |
| blk_total | input | BLK_W | Total block count of the medium |
| nat_cyls | input | 16 | Native cylinder count |
| nat_heads | input | 8 | Native head count |
| nat_spt | input | 8 | Native sectors per track |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| lba | output | LBA_W | Translated sector index |
| addr_err | output | 1 | Address rejected |
| geo_cyls | output | BLK_W | Current logical cylinder count |
| geo_heads | output | HD_W | Current logical head count |
| geo_spt | output | SPT_W | Current logical sectors per track |
| wb_cyl | output | 16 | Recalibrate cylinder value |
| wb_devhd | output | 8 | Recalibrate device/head value |
| wb_sect | output | 8 | Recalibrate sector value |

## Verification
The hardest state to reach is an operation strobe that lands while a long division is still running. The ignored load must leave no trace. The stimulus starts a set-geometry operation, which runs a multiply and then a 32-step divide. On the next cycle it strobes a load-defaults operation with different native parameters. It then watches for a second `done` over many cycles and confirms that the geometry equals the set-geometry result. The legacy-layout branch and the 256-sector encoding are reached with native heads of 255 and a sector count of 0. Translations at the last valid cylinder and sector confirm the exact upper bounds.

// File: rtl/chs_pkg.sv
package chs_pkg;
  typedef enum logic [1:0] {
    OP_XLT   = 2'd0,
    OP_SETG  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_RECAL = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_CH,
    ST_MUL_S,
    ST_GMUL,
    ST_DIV,
    ST_FIN
  } st_e;

  localparam int DEV_LBA_BIT = 6;
endpackage

// File: rtl/chs_seq_mul.sv
module chs_seq_mul #(
  parameter int A_W = 32,
  parameter int B_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           done,
  output logic [A_W-1:0] prod
);
  localparam int CNT_W = $clog2(B_W + 1);

  logic [A_W-1:0]   a_sh;
  logic [A_W-1:0]   acc;
  logic [B_W-1:0]   b_sh;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      acc  <= '0;
      b_sh <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_sh <= a;
        b_sh <= b;
        acc  <= '0;
        cnt  <= CNT_W'(B_W);
        run  <= 1'b1;
      end else if (run) begin
        if (b_sh[0]) acc <= acc + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/chs_seq_div.sv
module chs_seq_div #(
  parameter int N_W = 32,
  parameter int D_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [N_W-1:0] quot
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W:0]     rem;
  logic [D_W:0]     den_q;
  logic [D_W:0]     trial;
  logic [N_W-1:0]   dvd;
  logic [N_W-1:0]   q;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_comb trial = {rem[D_W-1:0], dvd[N_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_q <= '0;
      dvd   <= '0;
      q     <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q <= '0;
        if (den == '0) begin
          done <= 1'b1;
        end else begin
          dvd   <= num;
          rem   <= '0;
          den_q <= {1'b0, den};
          cnt   <= CNT_W'(N_W);
          run   <= 1'b1;
        end
      end else if (run) begin
        if (trial >= den_q) begin
          rem <= trial - den_q;
          q   <= {q[N_W-2:0], 1'b1};
        end else begin
          rem <= trial;
          q   <= {q[N_W-2:0], 1'b0};
        end
        dvd <= dvd << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q;
endmodule

// File: rtl/chs_addr_decode.sv
module chs_addr_decode #(
  parameter int LBA_W = 28,
  parameter int BLK_W = 32,
  parameter int HD_W  = 5,
  parameter int SPT_W = 9
) (
  input  logic [7:0]       devhd,
  input  logic [7:0]       sect,
  input  logic [15:0]      cyl,
  input  logic [BLK_W-1:0] geo_c,
  input  logic [HD_W-1:0]  geo_h,
  input  logic [SPT_W-1:0] geo_s,
  output logic             lba_mode,
  output logic [3:0]       head,
  output logic [LBA_W-1:0] lba_direct,
  output logic             chs_err
);
  import chs_pkg::*;

  logic cyl_bad, head_bad, sect_zero, sect_big;

  always_comb begin
    lba_mode   = devhd[DEV_LBA_BIT];
    head       = devhd[3:0];
    lba_direct = LBA_W'({devhd[3:0], cyl, sect});
    cyl_bad    = BLK_W'(cyl) >= geo_c;
    head_bad   = HD_W'(head) >= geo_h;
    sect_zero  = (sect == 8'd0);
    sect_big   = SPT_W'(sect) > geo_s;
    chs_err    = cyl_bad | head_bad | sect_zero | sect_big;
  end
endmodule

// File: rtl/chs_lba_xlat.sv
module chs_lba_xlat #(
  parameter int LBA_W    = 28,
  parameter int BLK_W    = 32,
  parameter int HD_W     = 5,
  parameter int SPT_W    = 9,
  parameter int XL_HEADS = 16,
  parameter int XL_SPT   = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic [7:0]       tf_devhd,
  input  logic [7:0]       tf_scnt,
  input  logic [7:0]       tf_sect,
  input  logic [15:0]      tf_cyl,
  input  logic [BLK_W-1:0] blk_total,
  input  logic [15:0]      nat_cyls,
  input  logic [7:0]       nat_heads,
  input  logic [7:0]       nat_spt,
  output logic             busy,
  output logic             done,
  output logic [LBA_W-1:0] lba,
  output logic             addr_err,
  output logic [BLK_W-1:0] geo_cyls,
  output logic [HD_W-1:0]  geo_heads,
  output logic [SPT_W-1:0] geo_spt,
  output logic [15:0]      wb_cyl,
  output logic [7:0]       wb_devhd,
  output logic [7:0]       wb_sect
);
  import chs_pkg::*;

  localparam int GEO_W  = HD_W + SPT_W;
  localparam int XL_DIV = XL_HEADS * XL_SPT;

  st_e              state;
  logic [1:0]       op_q;
  logic [3:0]       head_q;
  logic [7:0]       sect_q;
  logic [BLK_W-1:0] tot_q;

  logic [LBA_W-1:0] pend_lba;
  logic             pend_err;
  logic [BLK_W-1:0] pend_c;
  logic [HD_W-1:0]  pend_h;
  logic [SPT_W-1:0] pend_s;
  logic [7:0]       pend_devhd;
  logic [7:0]       pend_sect;

  logic             mul_go, mul_done;
  logic [BLK_W-1:0] mul_a, mul_p;
  logic [SPT_W-1:0] mul_b;
  logic             div_go, div_done;
  logic [BLK_W-1:0] div_num, div_q;
  logic [GEO_W-1:0] div_den;

  logic             dec_lba_mode, dec_err;
  logic [3:0]       dec_head;
  logic [LBA_W-1:0] dec_lba;

  logic [SPT_W-1:0] new_s;
  logic [HD_W-1:0]  new_h;

  chs_addr_decode #(
    .LBA_W(LBA_W), .BLK_W(BLK_W), .HD_W(HD_W), .SPT_W(SPT_W)
  ) u_dec (
    .devhd(tf_devhd), .sect(tf_sect), .cyl(tf_cyl),
    .geo_c(geo_cyls), .geo_h(geo_heads), .geo_s(geo_spt),
    .lba_mode(dec_lba_mode), .head(dec_head),
    .lba_direct(dec_lba), .chs_err(dec_err)
  );

  chs_seq_mul #(.A_W(BLK_W), .B_W(SPT_W)) u_mul (
    .clk(clk), .rst(rst), .start(mul_go), .a(mul_a), .b(mul_b),
    .done(mul_done), .prod(mul_p)
  );

  chs_seq_div #(.N_W(BLK_W), .D_W(GEO_W)) u_div (
    .clk(clk), .rst(rst), .start(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quot(div_q)
  );

  always_comb begin
    new_s = (tf_scnt == 8'd0) ? SPT_W'(256) : SPT_W'(tf_scnt);
    new_h = HD_W'(tf_devhd[3:0]) + HD_W'(1);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_XLT;
      head_q     <= '0;
      sect_q     <= '0;
      tot_q      <= '0;
      pend_lba   <= '0;
      pend_err   <= 1'b0;
      pend_c     <= '0;
      pend_h     <= '0;
      pend_s     <= '0;
      pend_devhd <= '0;
      pend_sect  <= '0;
      mul_go     <= 1'b0;
      mul_a      <= '0;
      mul_b      <= '0;
      div_go     <= 1'b0;
      div_num    <= '0;
      div_den    <= '0;
      done       <= 1'b0;
      lba        <= '0;
      addr_err   <= 1'b0;
      geo_cyls   <= '0;
      geo_heads  <= '0;
      geo_spt    <= '0;
      wb_cyl     <= '0;
      wb_devhd   <= '0;
      wb_sect    <= '0;
    end else begin
      mul_go <= 1'b0;
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (op_valid) begin
            op_q     <= op_code;
            pend_err <= 1'b0;
            case (op_code)
              OP_XLT: begin
                if (dec_lba_mode) begin
                  pend_lba <= dec_lba;
                  state    <= ST_FIN;
                end else if (dec_err) begin
                  pend_lba <= '0;
                  pend_err <= 1'b1;
                  state    <= ST_FIN;
                end else begin
                  mul_a  <= BLK_W'(tf_cyl);
                  mul_b  <= SPT_W'(geo_heads);
                  mul_go <= 1'b1;
                  head_q <= dec_head;
                  sect_q <= tf_sect;
                  state  <= ST_MUL_CH;
                end
              end
              OP_SETG: begin
                pend_s <= new_s;
                pend_h <= new_h;
                mul_a  <= BLK_W'(new_s);
                mul_b  <= SPT_W'(new_h);
                mul_go <= 1'b1;
                tot_q  <= blk_total;
                state  <= ST_GMUL;
              end
              OP_LOAD: begin
                if (nat_heads > 8'(XL_HEADS)) begin
                  pend_h  <= HD_W'(XL_HEADS);
                  pend_s  <= SPT_W'(XL_SPT);
                  div_num <= blk_total;
                  div_den <= GEO_W'(XL_DIV);
                  div_go  <= 1'b1;
                  state   <= ST_DIV;
                end else begin
                  pend_c <= BLK_W'(nat_cyls);
                  pend_h <= HD_W'(nat_heads);
                  pend_s <= SPT_W'(nat_spt);
                  state  <= ST_FIN;
                end
              end
              default: begin
                pend_devhd <= {tf_devhd[7:4], 4'd0};
                pend_sect  <= tf_devhd[DEV_LBA_BIT] ? 8'd0 : 8'd1;
                state      <= ST_FIN;
              end
            endcase
          end
        end
        ST_MUL_CH: begin
          if (mul_done) begin
            mul_a  <= mul_p + BLK_W'(head_q);
            mul_b  <= geo_spt;
            mul_go <= 1'b1;
            state  <= ST_MUL_S;
          end
        end
        ST_MUL_S: begin
          if (mul_done) begin
            pend_lba <= LBA_W'(mul_p + BLK_W'(sect_q) - BLK_W'(1));
            state    <= ST_FIN;
          end
        end
        ST_GMUL: begin
          if (mul_done) begin
            div_num <= tot_q;
            div_den <= GEO_W'(mul_p);
            div_go  <= 1'b1;
            state   <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            pend_c <= div_q;
            state  <= ST_FIN;
          end
        end
        default: begin
          done     <= 1'b1;
          addr_err <= pend_err;
          if (op_q == OP_XLT) lba <= pend_lba;
          if (op_q == OP_SETG || op_q == OP_LOAD) begin
            geo_cyls  <= pend_c;
            geo_heads <= pend_h;
            geo_spt   <= pend_s;
          end
          if (op_q == OP_RECAL) begin
            wb_cyl   <= 16'd0;
            wb_devhd <= pend_devhd;
            wb_sect  <= pend_sect;
          end
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/chs_lba_xlat_chk.sv
module chs_lba_xlat_chk #(
  parameter int BLK_W = 32,
  parameter int HD_W  = 5,
  parameter int SPT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             busy,
  input logic             done,
  input logic             addr_err,
  input logic [1:0]       op_q,
  input logic [BLK_W-1:0] geo_cyls,
  input logic [HD_W-1:0]  geo_heads,
  input logic [SPT_W-1:0] geo_spt,
  input logic [15:0]      wb_cyl,
  input logic [7:0]       wb_devhd,
  input logic [7:0]       wb_sect
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> busy);

  p_geo_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(geo_cyls) && $stable(geo_heads) && $stable(geo_spt)));

  p_op_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_q));

  p_geo_range_r4: assert property (@(posedge clk) disable iff (rst)
    (geo_heads <= HD_W'(16)) && (geo_spt <= SPT_W'(256)));

  p_err_xlt_only_r3: assert property (@(posedge clk) disable iff (rst)
    (done && op_q != 2'd0) |-> !addr_err);

  p_recal_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 2'd3) |-> (wb_cyl == 16'd0 && wb_devhd[3:0] == 4'd0 &&
                                wb_sect == (wb_devhd[6] ? 8'd0 : 8'd1)));
endmodule

bind chs_lba_xlat chs_lba_xlat_chk #(
  .BLK_W(BLK_W), .HD_W(HD_W), .SPT_W(SPT_W)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .busy(busy), .done(done),
  .addr_err(addr_err), .op_q(op_q), .geo_cyls(geo_cyls),
  .geo_heads(geo_heads), .geo_spt(geo_spt), .wb_cyl(wb_cyl),
  .wb_devhd(wb_devhd), .wb_sect(wb_sect)
);

// File: tb/test_chs_lba_xlat.sv
`timescale 1ns/1ps
module test_chs_lba_xlat;
  localparam int LBA_W = 28;
  localparam int BLK_W = 32;
  localparam int HD_W  = 5;
  localparam int SPT_W = 9;
  localparam int TOTAL = 1000000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_valid = 1'b0;
  logic [1:0]       op_code = '0;
  logic [7:0]       tf_devhd = '0, tf_scnt = '0, tf_sect = '0;
  logic [15:0]      tf_cyl = '0;
  logic [BLK_W-1:0] blk_total = BLK_W'(TOTAL);
  logic [15:0]      nat_cyls = 16'd100;
  logic [7:0]       nat_heads = 8'd4;
  logic [7:0]       nat_spt = 8'd17;
  logic             busy, done, addr_err;
  logic [LBA_W-1:0] lba;
  logic [BLK_W-1:0] geo_cyls;
  logic [HD_W-1:0]  geo_heads;
  logic [SPT_W-1:0] geo_spt;
  logic [15:0]      wb_cyl;
  logic [7:0]       wb_devhd, wb_sect;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  chs_lba_xlat i_chs_lba_xlat (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .tf_devhd(tf_devhd), .tf_scnt(tf_scnt), .tf_sect(tf_sect), .tf_cyl(tf_cyl),
    .blk_total(blk_total), .nat_cyls(nat_cyls), .nat_heads(nat_heads),
    .nat_spt(nat_spt), .busy(busy), .done(done), .lba(lba), .addr_err(addr_err),
    .geo_cyls(geo_cyls), .geo_heads(geo_heads), .geo_spt(geo_spt),
    .wb_cyl(wb_cyl), .wb_devhd(wb_devhd), .wb_sect(wb_sect)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [1:0]  op;
    logic [7:0]  devhd;
    logic [7:0]  scnt;
    logic [7:0]  sect;
    logic [15:0] cyl;
    logic [7:0]  nheads;
    logic [27:0] xlba;
    logic        xerr;
    logic [31:0] xc;
    logic [4:0]  xh;
    logic [8:0]  xs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{"R5", 2'd2, 8'hA0, 8'd0,  8'd0,   16'd0,    8'd4,   28'd0,       1'b0, 32'd100,   5'd4,  9'd17},
    '{"R2", 2'd0, 8'hA2, 8'd0,  8'd3,   16'd5,    8'd4,   28'd376,     1'b0, 32'd0,     5'd0,  9'd0},
    '{"R2", 2'd0, 8'hA3, 8'd0,  8'd17,  16'd99,   8'd4,   28'd6799,    1'b0, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hA0, 8'd0,  8'd1,   16'd100,  8'd4,   28'd0,       1'b1, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hA4, 8'd0,  8'd1,   16'd0,    8'd4,   28'd0,       1'b1, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hA0, 8'd0,  8'd0,   16'd0,    8'd4,   28'd0,       1'b1, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hA0, 8'd0,  8'd18,  16'd0,    8'd4,   28'd0,       1'b1, 32'd0,     5'd0,  9'd0},
    '{"R1", 2'd0, 8'h4A, 8'd0,  8'h56,  16'h1234, 8'd4,   28'hA123456, 1'b0, 32'd0,     5'd0,  9'd0},
    '{"R4", 2'd1, 8'hAF, 8'd0,  8'd0,   16'd0,    8'd4,   28'd0,       1'b0, 32'd244,   5'd16, 9'd256},
    '{"R2", 2'd0, 8'hAF, 8'd0,  8'd255, 16'd243,  8'd4,   28'd999422,  1'b0, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hA0, 8'd0,  8'd1,   16'd244,  8'd4,   28'd0,       1'b1, 32'd0,     5'd0,  9'd0},
    '{"R4", 2'd1, 8'hA3, 8'd17, 8'd0,   16'd0,    8'd4,   28'd0,       1'b0, 32'd14705, 5'd4,  9'd17},
    '{"R5", 2'd2, 8'hA0, 8'd0,  8'd0,   16'd0,    8'd255, 28'd0,       1'b0, 32'd992,   5'd16, 9'd63},
    '{"R2", 2'd0, 8'hAF, 8'd0,  8'd63,  16'd991,  8'd255, 28'd999935,  1'b0, 32'd0,     5'd0,  9'd0},
    '{"R3", 2'd0, 8'hAF, 8'd0,  8'd64,  16'd0,    8'd255, 28'd0,       1'b1, 32'd0,     5'd0,  9'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] dh, input logic [7:0] sc,
                       input logic [7:0] se, input logic [15:0] cy, input logic [7:0] nh);
    @(negedge clk);
    op_code = op; tf_devhd = dh; tf_scnt = sc; tf_sect = se; tf_cyl = cy;
    nat_heads = nh; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, "done seen", done, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R7", "watchdog", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(busy == 1'b0 && done == 1'b0, "R8", "busy/done after reset", {busy, done}, 0);
    check(geo_cyls == 0 && geo_heads == 0 && geo_spt == 0, "R8", "geometry after reset",
          geo_cyls, 0);
    issue(2'd0, 8'hA0, 8'd0, 8'd1, 16'd0, 8'd4);
    wait_done("R8");
    check(addr_err == 1'b1, "R8", "chs rejected with zero geometry", addr_err, 1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("%s", TBL[i].tag);
      issue(TBL[i].op, TBL[i].devhd, TBL[i].scnt, TBL[i].sect, TBL[i].cyl, TBL[i].nheads);
      wait_done(t);
      check(addr_err == TBL[i].xerr, t, $sformatf("err vec %0d", i), addr_err, TBL[i].xerr);
      if (TBL[i].op == 2'd0) begin
        if (!TBL[i].xerr)
          check(lba == TBL[i].xlba, t, $sformatf("lba vec %0d", i), lba, TBL[i].xlba);
      end else begin
        check(geo_cyls == TBL[i].xc, t, $sformatf("cyls vec %0d", i), geo_cyls, TBL[i].xc);
        check(geo_heads == TBL[i].xh, t, $sformatf("heads vec %0d", i), geo_heads, TBL[i].xh);
        check(geo_spt == TBL[i].xs, t, $sformatf("spt vec %0d", i), geo_spt, TBL[i].xs);
      end
    end

    // R7: done is one cycle, result holds
    issue(2'd0, 8'hA0, 8'd0, 8'd2, 16'd1, 8'd255);
    wait_done("R7");
    check(lba == 28'd1009, "R7", "lba in done cycle", lba, 1009);
    @(negedge clk);
    check(done == 1'b0, "R7", "done width one cycle", done, 0);
    repeat (10) @(negedge clk);
    check(lba == 28'd1009, "R7", "lba held", lba, 1009);

    // R6: recalibrate in both modes
    issue(2'd3, 8'hE5, 8'd0, 8'd9, 16'd77, 8'd255);
    wait_done("R6");
    check(wb_cyl == 16'd0, "R6", "cyl cleared", wb_cyl, 0);
    check(wb_devhd == 8'hE0, "R6", "devhd linear", wb_devhd, 8'hE0);
    check(wb_sect == 8'd0, "R6", "sector linear", wb_sect, 0);
    issue(2'd3, 8'hA7, 8'd0, 8'd9, 16'd77, 8'd255);
    wait_done("R6");
    check(wb_devhd == 8'hA0, "R6", "devhd chs", wb_devhd, 8'hA0);
    check(wb_sect == 8'd1, "R6", "sector chs", wb_sect, 1);

    // R9: strobe during a running set-geometry is ignored
    @(negedge clk);
    op_code = 2'd1; tf_devhd = 8'hA3; tf_scnt = 8'd17; op_valid = 1'b1;
    @(negedge clk);
    op_code = 2'd2; nat_heads = 8'd4; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    wait_done("R9");
    check(geo_cyls == 32'd14705, "R9", "cyls after ignored load", geo_cyls, 14705);
    check(geo_heads == 5'd4 && geo_spt == 9'd17, "R9", "heads/spt after ignored load",
          {geo_heads, geo_spt}, {5'd4, 9'd17});
    begin
      int extra = 0;
      @(negedge clk);
      for (int k = 0; k < 60; k++) begin
        if (done) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R9", "no second done", extra, 0);
    end
    check(geo_cyls == 32'd14705, "R9", "cyls still held", geo_cyls, 14705);

    finish_run();
  end
endmodule